// File: doc/BRIEF.md
# Descriptor List Dispatcher with Channel Sync Stall

The dispatcher walks a linear list of descriptors held in a word-addressed memory and routes each descriptor by the packet type carried in the top five bits of its fourth word. Data-transfer descriptors are eight words long and leave on a wide data-transfer port. Configuration descriptors are four words long and leave on a configuration port. Control descriptors are four words long and are acted on inside the dispatcher. The one control action it carries out is a channel sync. Processing halts at that descriptor until the named channel has reported completion.

Software or a sequencer gives a list start address and a size in words, then pulses a start strobe. The dispatcher always fetches four words first, because the type is only known once the fourth word has arrived. For a data-transfer descriptor it then fetches four more. Channel completions arrive as pulses on a per-channel vector and are kept in sticky bits, so a completion that arrives before its sync descriptor is not lost. Malformed descriptors set an error flag and are skipped. When the list is used up, a one-cycle list-complete interrupt is raised.

Top module: `dlq_dispatch`

## Requirements
- R1: While reset is held, mem_rd, dt_valid, cfg_valid, list_irq and err are all low.
- R2: A descriptor whose fourth word has bits 31:27 equal to 0x0A is fetched as eight words. It is presented for one cycle on dt_desc with dt_valid high, word i of the descriptor at bits 32*i+31 down to 32*i.
- R3: A descriptor whose fourth word has bits 31:27 equal to 0x0B is presented for one cycle on cfg_desc with cfg_valid high, word i at bits 32*i+31 down to 32*i. At most one of dt_valid, cfg_valid and list_irq is high in any cycle.
- R4: Descriptors are handled in list order, starting at list_addr. Each descriptor begins at the word that follows the previous one.
- R5: A control descriptor (bits 31:27 equal to 0x0C) with control type 4 in bits 3:0 and a channel number below NCH in bits 23:16 stalls the list. No later descriptor is emitted and no interrupt is raised until that channel's completion has been recorded.
- R6: A pulse on chan_done[c] sets a sticky completion bit for channel c, even when no sync is waiting. A sync on channel c consumes the bit, so a second sync on the same channel waits for a fresh pulse.
- R7: A packet type other than 0x0A, 0x0B or 0x0C, a control type other than 4, or a sync channel of NCH or above sets err. The four words are skipped and processing continues.
- R8: When the remaining size reaches zero at a descriptor boundary, list_irq is high for exactly one cycle and the dispatcher returns to idle. A size of zero raises the interrupt without any memory read.
- R9: A remaining size below four words at a descriptor boundary, or a data-transfer descriptor with fewer than eight words left, sets err and ends the list with list_irq. The truncated descriptor is not emitted.
- R10: A start pulse while a list is in progress is ignored. err stays set after a list ends and is cleared only when the next list is accepted.
- R11: Memory reads are one word per cycle at consecutive addresses, with read data expected on mem_rdata in the cycle after mem_rd. A list reads exactly the words of the descriptors it examines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin processing a list (accepted only when idle) |
| list_addr | input | AW | Word address of the first descriptor |
| list_words | input | LW | List size in words |
| chan_done | input | NCH | Per-channel completion pulses |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read word address |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| dt_valid | output | 1 | Data-transfer descriptor present on dt_desc |
| dt_desc | output | 256 | Eight-word data-transfer descriptor |
| cfg_valid | output | 1 | Configuration descriptor present on cfg_desc |
| cfg_desc | output | 128 | Four-word configuration descriptor |
| list_irq | output | 1 | One-cycle list-complete interrupt |
| err | output | 1 | Sticky error flag for the current list |

## Verification
The in-RTL properties watch, on every cycle, that the output strobes and the interrupt never overlap, that a waiting sync holds its state until its channel bit is set, that a completion pulse always leaves its sticky bit set, that err persists until a new list is accepted, and that memory reads and fill completions happen only while a fetch is expected. The bench scenarios are needed to show that descriptor contents arrive word for word in list order, that routing by packet type is correct, that the skip and truncation paths read the right number of words, and that an early completion is consumed exactly once.

// File: rtl/dlq_pkg.sv
// Package: shared constants, state type and header field helpers for the
// descriptor list dispatcher. Assumes 32-bit memory words.
package dlq_pkg;
    localparam int WORD_W    = 32;
    localparam int HDR_WORDS = 4;
    localparam int DT_WORDS  = 8;

    localparam logic [4:0] PKT_DATA = 5'h0A;
    localparam logic [4:0] PKT_CFG  = 5'h0B;
    localparam logic [4:0] PKT_CTRL = 5'h0C;

    localparam logic [3:0] CTL_SYNC_CHAN = 4'd4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_HDR,
        S_DECODE,
        S_TAIL,
        S_DT_OUT,
        S_CFG_OUT,
        S_WAIT,
        S_DONE
    } dlq_state_e;

    function automatic logic [4:0] hdr_pkt(input logic [WORD_W-1:0] w);
        return w[31:27];
    endfunction

    function automatic logic [3:0] hdr_ctl(input logic [WORD_W-1:0] w);
        return w[3:0];
    endfunction

    function automatic logic [7:0] hdr_chan(input logic [WORD_W-1:0] w);
        return w[23:16];
    endfunction
endpackage

// File: rtl/dlq_fetch.sv
// Fetch unit: on go, reads go_count consecutive words from go_addr, one per
// cycle, and writes them into a word buffer from slot go_first upward.
// Assumes read data returns one cycle after the request and that go is only
// raised while no fetch is running. done pulses in the cycle the last word
// is written; the buffer holds it from the next cycle on.
module dlq_fetch #(
    parameter int AW     = 16,
    parameter int NWORDS = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            go,
    input  logic [AW-1:0]                   go_addr,
    input  logic [$clog2(NWORDS)-1:0]       go_first,
    input  logic [$clog2(NWORDS):0]         go_count,
    output logic                            mem_rd,
    output logic [AW-1:0]                   mem_addr,
    input  logic [dlq_pkg::WORD_W-1:0]      mem_rdata,
    output logic                            done,
    output logic [NWORDS*dlq_pkg::WORD_W-1:0] words
);
    import dlq_pkg::*;

    localparam int IW = $clog2(NWORDS);

    logic              act_q;
    logic [AW-1:0]     addr_q;
    logic [IW:0]       left_q;
    logic [IW-1:0]     slot_q;
    logic              cap_v_q;
    logic              cap_last_q;
    logic [IW-1:0]     cap_slot_q;
    logic [WORD_W-1:0] buf_q [NWORDS];

    // Issue side: walk addresses and count outstanding reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            addr_q <= '0;
            left_q <= '0;
            slot_q <= '0;
        end else if (go) begin
            act_q  <= 1'b1;
            addr_q <= go_addr;
            left_q <= go_count;
            slot_q <= go_first;
        end else if (act_q) begin
            addr_q <= addr_q + AW'(1);
            left_q <= left_q - 1'b1;
            slot_q <= slot_q + 1'b1;
            if (left_q == (IW+1)'(1)) act_q <= 1'b0;
        end
    end

    // Capture side: track which slot the returning word belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v_q    <= 1'b0;
            cap_last_q <= 1'b0;
            cap_slot_q <= '0;
        end else begin
            cap_v_q    <= act_q;
            cap_last_q <= act_q && (left_q == (IW+1)'(1));
            cap_slot_q <= slot_q;
        end
    end

    // Buffer write: store each returning word in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) buf_q[i] <= '0;
        end else if (cap_v_q) begin
            buf_q[cap_slot_q] <= mem_rdata;
        end
    end

    generate
        for (genvar g = 0; g < NWORDS; g++) begin : g_flat
            assign words[g*WORD_W +: WORD_W] = buf_q[g];
        end
    endgenerate

    assign mem_rd   = act_q;
    assign mem_addr = addr_q;
    assign done     = cap_v_q && cap_last_q;

    // R11: a new fetch is never started over a running one.
    p_go_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !act_q);
endmodule

// File: rtl/dlq_sync_tab.sv
// Completion table: one sticky bit per channel, set by a completion pulse
// and cleared when a sync descriptor consumes it. A pulse in the same cycle
// as the consumption leaves the bit set, so it counts as a fresh completion.
module dlq_sync_tab #(
    parameter int NCH = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NCH-1:0]                      chan_done,
    input  logic                                consume,
    input  logic [(NCH > 1 ? $clog2(NCH) : 1)-1:0] sel,
    output logic [NCH-1:0]                      pend
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            logic hit;
            assign hit = consume && (int'(sel) == c);

            // Sticky bit update for channel c.
            always_ff @(posedge clk) begin
                if (!rst_n) pend[c] <= 1'b0;
                else        pend[c] <= (pend[c] && !hit) || chan_done[c];
            end

            // R6: a completion pulse is always remembered.
            p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
                chan_done[c] |=> pend[c]);
        end
    endgenerate

    // R6: only a recorded completion can be consumed.
    p_consume_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> pend[sel]);
endmodule

// File: rtl/dlq_dispatch.sv
// Descriptor list dispatcher. Walks a list of descriptors in word memory,
// reads four header words, classifies by the packet type in word 3, reads
// four more for data-transfer descriptors, and emits them on the matching
// port. Control descriptors of the channel-sync kind stall the list until
// the channel's sticky completion bit is set. Assumes a memory with a fixed
// one-cycle read latency and that output consumers accept every strobe.
module dlq_dispatch #(
    parameter int AW  = 16,
    parameter int LW  = 16,
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [AW-1:0]         list_addr,
    input  logic [LW-1:0]         list_words,
    input  logic [NCH-1:0]        chan_done,
    output logic                  mem_rd,
    output logic [AW-1:0]         mem_addr,
    input  logic [31:0]           mem_rdata,
    output logic                  dt_valid,
    output logic [255:0]          dt_desc,
    output logic                  cfg_valid,
    output logic [127:0]          cfg_desc,
    output logic                  list_irq,
    output logic                  err
);
    import dlq_pkg::*;

    localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int IW    = $clog2(DT_WORDS);
    localparam int BUF_W = DT_WORDS * WORD_W;
    localparam int CFG_W = HDR_WORDS * WORD_W;
    localparam logic [LW-1:0] SZ_HDR = LW'(HDR_WORDS);
    localparam logic [LW-1:0] SZ_DT  = LW'(DT_WORDS);

    dlq_state_e        state_q;
    logic [AW-1:0]     cur_q;
    logic [LW-1:0]     remain_q;
    logic              err_q;
    logic [CW-1:0]     sync_ch_q;

    logic              f_go;
    logic [AW-1:0]     f_addr;
    logic [IW-1:0]     f_first;
    logic [IW:0]       f_count;
    logic              f_done;
    logic [BUF_W-1:0]  f_words;
    logic [NCH-1:0]    pend;
    logic              consume;

    logic [WORD_W-1:0] hdr;
    logic [4:0]        ptype;
    logic [3:0]        ctype;
    logic [7:0]        src;
    logic              src_ok;

    dlq_fetch #(.AW(AW), .NWORDS(DT_WORDS)) i_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (f_go),
        .go_addr  (f_addr),
        .go_first (f_first),
        .go_count (f_count),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .done     (f_done),
        .words    (f_words)
    );

    dlq_sync_tab #(.NCH(NCH)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_done(chan_done),
        .consume  (consume),
        .sel      (sync_ch_q),
        .pend     (pend)
    );

    // Header field extraction from the buffered fourth word.
    always_comb begin
        hdr    = f_words[3*WORD_W +: WORD_W];
        ptype  = hdr_pkt(hdr);
        ctype  = hdr_ctl(hdr);
        src    = hdr_chan(hdr);
        src_ok = (int'(src) < NCH);
    end

    // Fetch requests and sync consumption for the current state.
    always_comb begin
        f_go    = 1'b0;
        f_addr  = cur_q;
        f_first = '0;
        f_count = (IW+1)'(HDR_WORDS);
        if (state_q == S_CHECK && remain_q >= SZ_HDR && remain_q != '0) begin
            f_go = 1'b1;
        end else if (state_q == S_DECODE && ptype == PKT_DATA && remain_q >= SZ_DT) begin
            f_go    = 1'b1;
            f_addr  = cur_q + AW'(HDR_WORDS);
            f_first = IW'(HDR_WORDS);
        end
        consume = (state_q == S_WAIT) && pend[sync_ch_q];
    end

    // Main sequencer: list walk, classification, stall and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cur_q     <= '0;
            remain_q  <= '0;
            err_q     <= 1'b0;
            sync_ch_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    cur_q    <= list_addr;
                    remain_q <= list_words;
                    err_q    <= 1'b0;
                    state_q  <= S_CHECK;
                end
                S_CHECK: begin
                    if (remain_q == '0) begin
                        state_q <= S_DONE;
                    end else if (remain_q < SZ_HDR) begin
                        err_q   <= 1'b1;
                        state_q <= S_DONE;
                    end else begin
                        state_q <= S_HDR;
                    end
                end
                S_HDR: if (f_done) state_q <= S_DECODE;
                S_DECODE: begin
                    if (ptype == PKT_DATA) begin
                        if (remain_q >= SZ_DT) begin
                            state_q <= S_TAIL;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= S_DONE;
                        end
                    end else if (ptype == PKT_CFG) begin
                        state_q <= S_CFG_OUT;
                    end else if (ptype == PKT_CTRL && ctype == CTL_SYNC_CHAN && src_ok) begin
                        sync_ch_q <= src[CW-1:0];
                        state_q   <= S_WAIT;
                    end else begin
                        err_q    <= 1'b1;
                        cur_q    <= cur_q + AW'(HDR_WORDS);
                        remain_q <= remain_q - SZ_HDR;
                        state_q  <= S_CHECK;
                    end
                end
                S_TAIL: if (f_done) state_q <= S_DT_OUT;
                S_DT_OUT: begin
                    cur_q    <= cur_q + AW'(DT_WORDS);
                    remain_q <= remain_q - SZ_DT;
                    state_q  <= S_CHECK;
                end
                S_CFG_OUT: begin
                    cur_q    <= cur_q + AW'(HDR_WORDS);
                    remain_q <= remain_q - SZ_HDR;
                    state_q  <= S_CHECK;
                end
                S_WAIT: if (consume) begin
                    cur_q    <= cur_q + AW'(HDR_WORDS);
                    remain_q <= remain_q - SZ_HDR;
                    state_q  <= S_CHECK;
                end
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign dt_valid  = (state_q == S_DT_OUT);
    assign cfg_valid = (state_q == S_CFG_OUT);
    assign list_irq  = (state_q == S_DONE);
    assign dt_desc   = f_words;
    assign cfg_desc  = f_words[CFG_W-1:0];
    assign err       = err_q;

    // R3: strobes and interrupt are mutually exclusive.
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dt_valid, cfg_valid, list_irq}));

    // R5: a sync without its completion keeps the list stalled.
    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !pend[sync_ch_q]) |=> (state_q == S_WAIT));

    // R8: the interrupt is a single cycle and leads back to idle.
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        list_irq |=> (!list_irq && state_q == S_IDLE));

    // R10: err only clears when a new list is accepted.
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(state_q == S_IDLE && start)) |=> err);

    // R11: no memory traffic while idle.
    p_no_read_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !mem_rd);

    // R11: fill completions only arrive while a fetch is awaited.
    p_fill_ctx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        f_done |-> (state_q == S_HDR || state_q == S_TAIL));
endmodule

// File: tb/test_dlq_dispatch.sv
module test_dlq_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  list_addr = '0;
    logic [15:0]  list_words = '0;
    logic [NCH-1:0] chan_done = '0;
    logic         mem_rd;
    logic [15:0]  mem_addr;
    logic [31:0]  mem_rdata = '0;
    logic         dt_valid;
    logic [255:0] dt_desc;
    logic         cfg_valid;
    logic [127:0] cfg_desc;
    logic         list_irq;
    logic         err;

    dlq_dispatch #(.AW(16), .LW(16), .NCH(NCH)) i_dlq_dispatch (
        .clk(clk), .rst_n(rst_n), .start(start), .list_addr(list_addr),
        .list_words(list_words), .chan_done(chan_done), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dt_valid(dt_valid),
        .dt_desc(dt_desc), .cfg_valid(cfg_valid), .cfg_desc(cfg_desc),
        .list_irq(list_irq), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem [0:255];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    int total = 0;
    int bad = 0;
    int n_dt = 0, n_cfg = 0, n_irq = 0, n_reads = 0, n_ev = 0;
    int ev_kind [64];
    logic [31:0] ev_w0 [64];
    logic [255:0] last_dt = '0;
    logic [127:0] last_cfg = '0;

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (dt_valid) begin
            ev_kind[n_ev % 64] = 1; ev_w0[n_ev % 64] = dt_desc[31:0];
            last_dt = dt_desc; n_dt++; n_ev++;
        end
        if (cfg_valid) begin
            ev_kind[n_ev % 64] = 2; ev_w0[n_ev % 64] = cfg_desc[31:0];
            last_cfg = cfg_desc; n_cfg++; n_ev++;
        end
        if (list_irq) n_irq++;
        if (mem_rd && rst_n) n_reads++;
    end

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic kick(input logic [15:0] a, input logic [15:0] w);
        tick(1);
        start = 1'b1; list_addr = a; list_words = w;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_irq(input int base_irq, input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            tick(1);
            if (n_irq > base_irq) seen = 1'b1;
        end
    endtask

    task automatic pulse_chan(input int c);
        tick(1);
        chan_done[c] = 1'b1;
        tick(1);
        chan_done = '0;
    endtask

    task automatic put_desc(input int base, input logic [31:0] w0,
                            input logic [31:0] w3, input int nw);
        for (int i = 0; i < nw; i++) mem[base + i] = w0 + 32'(i);
        mem[base + 3] = w3;
    endtask

    typedef struct packed {
        logic [31:0] w3;
        logic [7:0]  size;
        logic [3:0]  reads;
        logic        e_dt;
        logic        e_cfg;
        logic        e_err;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{32'h5000_0123, 8'd8, 4'd8, 1'b1, 1'b0, 1'b0},
        '{32'h5804_0010, 8'd4, 4'd4, 1'b0, 1'b1, 1'b0},
        '{32'h6800_0000, 8'd4, 4'd4, 1'b0, 1'b0, 1'b1},
        '{32'h6000_0006, 8'd4, 4'd4, 1'b0, 1'b0, 1'b1},
        '{32'h6009_0004, 8'd4, 4'd4, 1'b0, 1'b0, 1'b1},
        '{32'h5000_0777, 8'd4, 4'd4, 1'b0, 1'b0, 1'b1},
        '{32'h5800_0000, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0},
        '{32'h5800_0000, 8'd3, 4'd0, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen;
        bit ok;
        int s_dt, s_cfg, s_irq, s_rd, s_ev;
        for (int i = 0; i < 256; i++) mem[i] = '0;

        // R1: reset state.
        tick(3);
        check({mem_rd, dt_valid, cfg_valid, list_irq, err} == 5'b0,
              "R1 outputs in reset", {mem_rd, dt_valid, cfg_valid, list_irq, err}, 0);
        rst_n = 1'b1;
        tick(2);
        check(n_reads == 0, "R11 no read after reset", n_reads, 0);

        // Table walk: single-descriptor lists (R2 R3 R7 R8 R9 R11).
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w0;
            w0 = 32'hA000_0000 + 32'(k << 8);
            put_desc(16, w0, VEC[k].w3, 8);
            s_dt = n_dt; s_cfg = n_cfg; s_irq = n_irq; s_rd = n_reads;
            kick(16'd16, 16'(VEC[k].size));
            wait_irq(s_irq, 200, seen);
            check(seen, "R8 list_irq raised", 64'(seen), 1);
            check(n_dt - s_dt == int'(VEC[k].e_dt), "R2 R9 dt count", n_dt - s_dt, VEC[k].e_dt);
            check(n_cfg - s_cfg == int'(VEC[k].e_cfg), "R3 R9 cfg count", n_cfg - s_cfg, VEC[k].e_cfg);
            check(err == VEC[k].e_err, "R7 R9 R10 err flag", err, VEC[k].e_err);
            check(n_reads - s_rd == int'(VEC[k].reads), "R11 read count", n_reads - s_rd, VEC[k].reads);
            if (VEC[k].e_dt) begin
                ok = 1'b1;
                for (int i = 0; i < 8; i++)
                    if (last_dt[32*i +: 32] != mem[16 + i]) ok = 1'b0;
                check(ok, "R2 dt words in order", last_dt[63:0], {mem[17], mem[16]});
            end
            if (VEC[k].e_cfg) begin
                ok = 1'b1;
                for (int i = 0; i < 4; i++)
                    if (last_cfg[32*i +: 32] != mem[16 + i]) ok = 1'b0;
                check(ok, "R3 cfg words in order", last_cfg[63:0], {mem[17], mem[16]});
            end
            tick(4);
            check(n_irq - s_irq == 1, "R8 single irq", n_irq - s_irq, 1);
            check(err == VEC[k].e_err, "R10 err held after list", err, VEC[k].e_err);
        end

        // R4: mixed list keeps order and contiguity.
        put_desc(64, 32'h1111_0000, 32'h5800_0001, 4);
        put_desc(68, 32'h2222_0000, 32'h5000_0002, 8);
        put_desc(76, 32'h3333_0000, 32'h5800_0003, 4);
        s_ev = n_ev; s_irq = n_irq; s_rd = n_reads;
        kick(16'd64, 16'd16);
        wait_irq(s_irq, 300, seen);
        check(n_ev - s_ev == 3, "R4 event count", n_ev - s_ev, 3);
        check(ev_kind[s_ev % 64] == 2 && ev_w0[s_ev % 64] == 32'h1111_0000,
              "R4 first is cfg A", ev_w0[s_ev % 64], 32'h1111_0000);
        check(ev_kind[(s_ev+1) % 64] == 1 && ev_w0[(s_ev+1) % 64] == 32'h2222_0000,
              "R4 second is dt B", ev_w0[(s_ev+1) % 64], 32'h2222_0000);
        check(ev_kind[(s_ev+2) % 64] == 2 && ev_w0[(s_ev+2) % 64] == 32'h3333_0000,
              "R4 third is cfg C", ev_w0[(s_ev+2) % 64], 32'h3333_0000);
        check(n_reads - s_rd == 16, "R11 mixed list reads", n_reads - s_rd, 16);
        check(err == 1'b0, "R10 err cleared by new list", err, 0);

        // R5: sync on channel 2 stalls until its completion.
        for (int i = 0; i < 3; i++) mem[96 + i] = '0;
        mem[99] = 32'h6002_0004;
        put_desc(100, 32'h4444_0000, 32'h5800_0004, 4);
        s_cfg = n_cfg; s_irq = n_irq;
        kick(16'd96, 16'd8);
        tick(40);
        check(n_cfg == s_cfg, "R5 cfg held behind sync", n_cfg - s_cfg, 0);
        check(n_irq == s_irq, "R5 no irq while stalled", n_irq - s_irq, 0);
        pulse_chan(5);
        tick(20);
        check(n_cfg == s_cfg, "R5 other channel does not release", n_cfg - s_cfg, 0);
        pulse_chan(2);
        wait_irq(s_irq, 100, seen);
        check(seen && n_cfg - s_cfg == 1, "R5 released by channel", n_cfg - s_cfg, 1);
        check(err == 1'b0, "R5 sync is not an error", err, 0);

        // R6: early completion is kept and consumed once.
        for (int i = 0; i < 3; i++) mem[128 + i] = '0;
        mem[131] = 32'h6003_0004;
        put_desc(132, 32'h5555_0000, 32'h5800_0005, 4);
        pulse_chan(3);
        tick(5);
        s_cfg = n_cfg; s_irq = n_irq;
        kick(16'd128, 16'd8);
        wait_irq(s_irq, 100, seen);
        check(seen && n_cfg - s_cfg == 1, "R6 early completion used", n_cfg - s_cfg, 1);
        s_cfg = n_cfg; s_irq = n_irq;
        kick(16'd128, 16'd8);
        tick(40);
        check(n_cfg == s_cfg, "R6 completion consumed once", n_cfg - s_cfg, 0);

        // R10: start while stalled is ignored.
        kick(16'd16, 16'd0);
        tick(10);
        check(n_irq == s_irq, "R10 start ignored while busy", n_irq - s_irq, 0);
        pulse_chan(3);
        wait_irq(s_irq, 100, seen);
        tick(10);
        check(n_irq - s_irq == 1 && n_cfg - s_cfg == 1, "R10 list finished once",
              n_irq - s_irq, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule